// File: doc/BRIEF.md
# GPIO Group Interrupt and Wake Status Bank

This block keeps the interrupt and wake state for one group of at most 24 pads. The pad logic supplies a vector of one-cycle event pulses, one bit per pad. Each pulse latches a pending bit into two sticky registers. The first is the interrupt status, which is masked by a per-pad interrupt enable. The second is the wake status, which is masked by a per-pad wake enable.

Software reaches the four registers through a small 32-bit register port. Writes take effect on the clock edge, and reads are combinational from the register contents. Both status registers are cleared by writing a one to a bit.

The block drives two registered outputs:
- `irq_out` is the OR of the enabled pending interrupts.
- `wake_out` is the OR of the enabled pending wake bits, leaving out any pad whose route-to-SCI input is high.

A group at the end of a pad range can hold fewer than 24 pads. `NUM_PADS` sets how many pad positions are live, and positions at or above it are ignored everywhere.

Top module: `gpio_irq_bank`

## Requirements
- R1: While `rst` is high and after it is released, all four registers read 0, and `irq_out` and `wake_out` are 0.
- R2: A pulse on `pad_event[i]` for a live pad sets bit i of the interrupt status register (offset 0x0). The bit stays set until it is cleared. Events on several pads accumulate.
- R3: Writing offset 0x0 clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_out` becomes the OR over live pads of (status AND interrupt enable) one clock after those register values, so there is one register stage.
- R6: The interrupt enable register (offset 0x4) and the wake enable register (offset 0xC) hold the written value for live pads. Bits 31:NUM_PADS read 0.
- R7: An event on a live pad also sets bit i of the wake status register (offset 0x8). That register is cleared by writing a one to a bit, in the same way as offset 0x0.
- R8: `wake_out` becomes the OR over live pads of (wake status AND wake enable AND NOT `route_sci`) one clock later. A pad with `route_sci` high never raises wake.
- R9: Pad positions at or above `NUM_PADS` never show a pending status bit, never hold an enable bit, and never raise either output.
- R10: The register map is: status 0x0, interrupt enable 0x4, wake status 0x8, wake enable 0xC. Any other `reg_addr` value reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_event | input | 24 | One-cycle event pulse per pad position |
| route_sci | input | 24 | Per pad: high when the pad is routed to SCI, which blocks wake |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq_out | output | 1 | Registered combined interrupt |
| wake_out | output | 1 | Registered combined wake request |

## Verification
The bound checker watches four things on every cycle:
- that an event on a live pad always leaves its status bit set, even against a same-cycle clear;
- that a clearing write drops exactly the addressed bits that saw no event;
- that dead pad positions never hold state;
- that both outputs track their masked OR with a one-cycle lag.

Some behaviour depends on the stimulus history, so only the bench scenarios can show it:
- the exact values read back through the register map;
- that a write of zero leaves the status untouched;
- that `route_sci` gates wake while the pending bit stays set;
- that writes to unmapped offsets change nothing.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int GRP_MAX = 24;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_STS  = 4'h0,
        OFS_IEN  = 4'h4,
        OFS_GSTS = 4'h8,
        OFS_GEN  = 4'hC
    } reg_ofs_e;

    typedef struct packed {
        logic sts;
        logic ien;
        logic gsts;
        logic gen;
    } reg_sel_t;

    function automatic reg_sel_t decode_ofs(logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.sts  = (a == OFS_STS);
        s.ien  = (a == OFS_IEN);
        s.gsts = (a == OFS_GSTS);
        s.gen  = (a == OFS_GEN);
        return s;
    endfunction

    function automatic logic [GRP_MAX-1:0] live_mask(int n);
        logic [GRP_MAX-1:0] m;
        for (int i = 0; i < GRP_MAX; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sticky_bank.sv
module gpio_sticky_bank #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_en,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_i[i]) begin
                bit_q <= 1'b1;
            end else if (clr_en && clr_i[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/gpio_any_reg.sv
module gpio_any_reg #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] vec,
    output logic         any_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            any_q <= 1'b0;
        end else begin
            any_q <= |vec;
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PADS = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GRP_MAX-1:0] pad_event,
    input  logic [GRP_MAX-1:0] route_sci,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              wake_out
);
    localparam int N = NUM_PADS;

    reg_sel_t sel;
    assign sel = decode_ofs(reg_addr);

    logic [N-1:0] evt_live, route_live, wdata_live;
    assign evt_live   = pad_event[N-1:0];
    assign route_live = route_sci[N-1:0];
    assign wdata_live = reg_wdata[N-1:0];

    logic [N-1:0] sts_n, ien_n, gsts_n, gen_n;

    gpio_sticky_bank #(.N(N)) u_sts (
        .clk(clk), .rst(rst), .set_i(evt_live),
        .clr_en(reg_wen && sel.sts), .clr_i(wdata_live), .q(sts_n)
    );

    gpio_sticky_bank #(.N(N)) u_gsts (
        .clk(clk), .rst(rst), .set_i(evt_live),
        .clr_en(reg_wen && sel.gsts), .clr_i(wdata_live), .q(gsts_n)
    );

    gpio_mask_reg #(.N(N)) u_ien (
        .clk(clk), .rst(rst), .we(reg_wen && sel.ien),
        .d(wdata_live), .q(ien_n)
    );

    gpio_mask_reg #(.N(N)) u_gen (
        .clk(clk), .rst(rst), .we(reg_wen && sel.gen),
        .d(wdata_live), .q(gen_n)
    );

    gpio_any_reg #(.N(N)) u_irq (
        .clk(clk), .rst(rst), .vec(sts_n & ien_n), .any_q(irq_out)
    );

    gpio_any_reg #(.N(N)) u_wake (
        .clk(clk), .rst(rst), .vec(gsts_n & gen_n & ~route_live),
        .any_q(wake_out)
    );

    // zero-extended views of the banks, used by read-back and the checker
    logic [GRP_MAX-1:0] sts_q, ien_q, gsts_q, gen_q;

    if (N < GRP_MAX) begin : g_partial
        assign sts_q  = {{(GRP_MAX-N){1'b0}}, sts_n};
        assign ien_q  = {{(GRP_MAX-N){1'b0}}, ien_n};
        assign gsts_q = {{(GRP_MAX-N){1'b0}}, gsts_n};
        assign gen_q  = {{(GRP_MAX-N){1'b0}}, gen_n};
        logic unused_dead_pads;
        assign unused_dead_pads = ^{pad_event[GRP_MAX-1:N], route_sci[GRP_MAX-1:N],
                                    reg_wdata[GRP_MAX-1:N]};
    end else begin : g_full
        assign sts_q  = sts_n;
        assign ien_q  = ien_n;
        assign gsts_q = gsts_n;
        assign gen_q  = gen_n;
    end

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:GRP_MAX];

    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            sel.sts:  reg_rdata[GRP_MAX-1:0] = sts_q;
            sel.ien:  reg_rdata[GRP_MAX-1:0] = ien_q;
            sel.gsts: reg_rdata[GRP_MAX-1:0] = gsts_q;
            sel.gen:  reg_rdata[GRP_MAX-1:0] = gen_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PADS = 24
) (
    input logic               clk,
    input logic               rst,
    input logic [GRP_MAX-1:0] pad_event,
    input logic [GRP_MAX-1:0] route_sci,
    input logic               reg_wen,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [GRP_MAX-1:0] sts_q,
    input logic [GRP_MAX-1:0] ien_q,
    input logic [GRP_MAX-1:0] gsts_q,
    input logic [GRP_MAX-1:0] gen_q,
    input logic               irq_out,
    input logic               wake_out
);
    localparam logic [GRP_MAX-1:0] LIVE = live_mask(NUM_PADS);

    logic wr_sts, wr_unmapped;
    assign wr_sts      = reg_wen && (reg_addr == OFS_STS);
    assign wr_unmapped = reg_wen && (reg_addr != OFS_STS) && (reg_addr != OFS_IEN)
                         && (reg_addr != OFS_GSTS) && (reg_addr != OFS_GEN);

    a_r1_outputs_low_after_reset: assert property (@(posedge clk)
        rst |=> (!irq_out && !wake_out));

    a_r4_event_sets_status: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pad_event) & LIVE & ~sts_q) == '0)
                 && (($past(pad_event) & LIVE & ~gsts_q) == '0));

    a_r3_clear_drops_bits: assert property (@(posedge clk) disable iff (rst)
        wr_sts |=> (($past(reg_wdata[GRP_MAX-1:0]) & ~$past(pad_event) & sts_q) == '0));

    a_r5_irq_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(sts_q & ien_q))));

    a_r8_wake_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wake_out == $past(|(gsts_q & gen_q & ~route_sci & LIVE))));

    a_r9_dead_pads_empty: assert property (@(posedge clk) disable iff (rst)
        ((sts_q | ien_q | gsts_q | gen_q) & ~LIVE) == '0);

    a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
        wr_unmapped |=> ($stable(ien_q) && $stable(gen_q)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PADS(NUM_PADS)) u_chk (
    .clk(clk), .rst(rst), .pad_event(pad_event), .route_sci(route_sci),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .sts_q(sts_q), .ien_q(ien_q), .gsts_q(gsts_q), .gen_q(gen_q),
    .irq_out(irq_out), .wake_out(wake_out)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
    localparam int NP = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pad_event = '0;
    logic [23:0] route_sci = '0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out, wake_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_irq_bank #(.NUM_PADS(NP)) u_gpio_irq_bank (
        .clk(clk), .rst(rst), .pad_event(pad_event), .route_sci(route_sci),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .wake_out(wake_out)
    );

    typedef enum logic [1:0] {K_RD, K_WR, K_EV} kind_e;
    typedef struct packed {
        kind_e       kind;
        logic [3:0]  addr;
        logic [31:0] data;
        logic        irq;
        logic        wake;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{K_RD, 4'h0, 32'h0,        1'b0, 1'b0, 4'd1},  // R1
        '{K_RD, 4'h4, 32'h0,        1'b0, 1'b0, 4'd1},  // R1
        '{K_RD, 4'h8, 32'h0,        1'b0, 1'b0, 4'd1},  // R1
        '{K_RD, 4'hC, 32'h0,        1'b0, 1'b0, 4'd1},  // R1
        '{K_EV, 4'h0, 32'h5,        1'b0, 1'b0, 4'd2},
        '{K_RD, 4'h0, 32'h5,        1'b0, 1'b0, 4'd2},  // R2
        '{K_RD, 4'h8, 32'h5,        1'b0, 1'b0, 4'd7},  // R7
        '{K_WR, 4'h4, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd6},
        '{K_RD, 4'h4, 32'h000FFFFF, 1'b1, 1'b0, 4'd6},  // R6 R5
        '{K_WR, 4'h0, 32'h4,        1'b0, 1'b0, 4'd3},
        '{K_RD, 4'h0, 32'h1,        1'b1, 1'b0, 4'd3},  // R3
        '{K_WR, 4'h0, 32'h0,        1'b0, 1'b0, 4'd3},
        '{K_RD, 4'h0, 32'h1,        1'b1, 1'b0, 4'd3},  // R3 zero write
        '{K_WR, 4'h0, 32'h1,        1'b0, 1'b0, 4'd5},
        '{K_RD, 4'h0, 32'h0,        1'b0, 1'b0, 4'd5},  // R5
        '{K_EV, 4'h0, 32'h00F00000, 1'b0, 1'b0, 4'd9},
        '{K_RD, 4'h0, 32'h0,        1'b0, 1'b0, 4'd9},  // R9
        '{K_RD, 4'h8, 32'h5,        1'b0, 1'b0, 4'd9},  // R9
        '{K_WR, 4'hC, 32'h1,        1'b0, 1'b0, 4'd8},
        '{K_RD, 4'hC, 32'h1,        1'b0, 1'b1, 4'd8},  // R8
        '{K_WR, 4'h8, 32'h1,        1'b0, 1'b0, 4'd7},
        '{K_RD, 4'h8, 32'h4,        1'b0, 1'b0, 4'd7},  // R7
        '{K_WR, 4'h2, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd10},
        '{K_RD, 4'h2, 32'h0,        1'b0, 1'b0, 4'd10}, // R10
        '{K_RD, 4'h0, 32'h0,        1'b0, 1'b0, 4'd10}, // R10
        '{K_RD, 4'h4, 32'h000FFFFF, 1'b0, 1'b0, 4'd10}, // R10
        '{K_RD, 4'hC, 32'h1,        1'b0, 1'b0, 4'd10}  // R10
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0;
        tick();
    endtask

    task automatic ev(input logic [23:0] v);
        @(negedge clk);
        pad_event = v;
        @(negedge clk);
        pad_event = '0;
        tick();
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [31:0] exp_d,
                          input logic exp_i, input logic exp_w, input int req);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp_d || irq_out !== exp_i || wake_out !== exp_w) begin
            n_fail++;
            $display("FAIL R%0d addr=%h rdata=%h irq=%b wake=%b expected rdata=%h irq=%b wake=%b",
                     req, a, reg_rdata, irq_out, wake_out, exp_d, exp_i, exp_w);
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs low while reset is held
        n_chk++;
        if (irq_out !== 1'b0 || wake_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset irq=%b wake=%b expected 0 0", irq_out, wake_out);
        end
        rst = 1'b0;
        tick();

        for (int k = 0; k < NV; k++) begin
            case (TBL[k].kind)
                K_WR: wr(TBL[k].addr, TBL[k].data);
                K_EV: ev(TBL[k].data[23:0]);
                default: chk_rd(TBL[k].addr, TBL[k].data, TBL[k].irq, TBL[k].wake,
                                int'(TBL[k].req));
            endcase
        end

        // R4: event and clearing write on bit 3 in the same cycle; the event wins
        @(negedge clk);
        pad_event = 24'h8; reg_wen = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h8;
        @(negedge clk);
        pad_event = '0; reg_wen = 1'b0; reg_wdata = '0;
        tick();
        chk_rd(4'h0, 32'h8, 1'b1, 1'b0, 4);

        // R8: the route-to-SCI input blocks wake; wake status is 0xC here
        @(negedge clk);
        route_sci = 24'h4;
        wr(4'hC, 32'h4);
        chk_rd(4'h8, 32'hC, 1'b1, 1'b0, 8);
        @(negedge clk);
        route_sci = '0;
        tick();
        chk_rd(4'hC, 32'h4, 1'b1, 1'b1, 8);

        // R2: events accumulate; R9: bit 19 is the last live pad
        wr(4'h0, 32'hFFFFFFFF);
        ev(24'h000001);
        ev(24'h080000);
        chk_rd(4'h0, 32'h00080001, 1'b1, 1'b1, 2);

        // R1: reset taken mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        tick();
        tick();
        chk_rd(4'h0, 32'h0, 1'b0, 1'b0, 1);
        chk_rd(4'h4, 32'h0, 1'b0, 1'b0, 1);
        chk_rd(4'h8, 32'h0, 1'b0, 1'b0, 1);
        chk_rd(4'hC, 32'h0, 1'b0, 1'b0, 1);
        rst = 1'b0;
        tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule